// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block runs on an always-on clock beside a small microcontroller core and decides when the core clock may run. A one-cycle request from the CPU stops the core clock through an enable output. The controller then waits for one of three wake sources: an external interrupt line, a digital flag from an analog threshold monitor, or an external hardware reset request.

An interrupt wake restarts the clock and raises a pending bit toward the interrupt controller. It also sets a flag that tells the CPU the return from that interrupt lands on the instruction after the power-down instruction. The external interrupt only counts as a wake when its configuration input marks it level-sensitive, because no edge can be sampled while the clock is stopped.

A reset wake restarts the clock and issues a clear pulse for the special function registers and display memory, along with a one-cycle program-counter-to-zero strobe. There is no clear for general RAM, so working RAM is kept. A two-bit status field records the source of the last wake, and a read strobe clears it.

Top module: `pdwake_ctrl`

## Requirements
- R1: After rst_n is released, core_clk_en_o is 1 and irq_pend_o, wake_src_o, reg_clr_o, pc_zero_o and resume_next_o are all 0.
- R2: pd_req_i sampled high while running drives core_clk_en_o low after that clock edge. It stays low for as long as no valid wake input is present. pd_req_i is ignored while the clock is already stopped.
- R3: While stopped, a valid wake input sampled at a clock edge drives core_clk_en_o high after that same edge.
- R4: While stopped, ext_irq_i has no effect when ext_lvl_i is 0 (edge-configured): the clock stays off and irq_pend_o[0] stays 0.
- R5: An external-interrupt wake sets irq_pend_o[0]. A pending bit holds until its irq_ack_i bit is high at an edge, and a set in the same cycle as an acknowledge wins.
- R6: resume_next_o is set by any interrupt wake. It is cleared when power-down is next entered or when hw_rst_i is seen.
- R7: A threshold wake (thr_flag_i) behaves like the external wake, but it sets irq_pend_o[1] and wake_src_o = 2.
- R8: hw_rst_i raises reg_clr_o for CLR_CYCLES cycles and pc_zero_o for one cycle, clears all pending bits and resume_next_o, and wakes a stopped core. pd_req_i is ignored while reg_clr_o is high. No RAM clear exists.
- R9: If hw_rst_i and an interrupt wake occur in the same cycle while stopped, reset wins: no pending bit is raised and wake_src_o = 3.
- R10: wake_src_o encodes the last wake as 0 none, 1 external, 2 threshold, 3 reset. A reset while running leaves it unchanged. stat_rd_i clears it to 0, but a wake capture in the same cycle wins over the read.
- R11: Interrupt inputs seen while the core clock runs set no pending bit.
- R12: If the external and threshold wakes arrive together, both pending bits are set and wake_src_o reports external (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on sampling clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| pd_req_i | input | 1 | One-cycle power-down request from the CPU |
| ext_irq_i | input | 1 | External interrupt line |
| ext_lvl_i | input | 1 | 1 = external interrupt configured level-sensitive |
| thr_flag_i | input | 1 | Threshold-compare flag from the analog monitor |
| hw_rst_i | input | 1 | External hardware reset request |
| stat_rd_i | input | 1 | Status read strobe, clears wake_src_o |
| irq_ack_i | input | 2 | Pending acknowledge, bit 0 external, bit 1 threshold |
| core_clk_en_o | output | 1 | Core clock enable |
| irq_pend_o | output | 2 | Pending wake interrupts, bit 0 external, bit 1 threshold |
| wake_src_o | output | 2 | Source of the last wake |
| resume_next_o | output | 1 | Return goes to the instruction after power-down |
| reg_clr_o | output | 1 | Register and display-memory clear |
| pc_zero_o | output | 1 | Restart program counter at 0000h |

## Verification
Two pairs of functions can land on the same edge. The first is a reset wake and an interrupt wake: hw_rst_i and a level-configured ext_irq_i are raised together while stopped, and the bench expects no pending bit, status code 3 and the clear pulse. The second is a status read and a wake capture: stat_rd_i is held high on the edge that wakes the core, and the bench expects the new source code rather than 0. A third collision, pd_req_i during the clear pulse or together with a running reset, is judged by the clock enable staying high.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;
   localparam int NIRQ = 2;

   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_EXT  = 2'd1,
      WK_THR  = 2'd2,
      WK_RST  = 2'd3
   } wake_src_e;
endpackage

// File: rtl/pdwake_arb.sv
// Qualifies the raw wake inputs: the external line counts only when
// configured level-sensitive.
module pdwake_arb (
   input  logic ext_irq,
   input  logic ext_lvl,
   input  logic thr_flag,
   input  logic hw_rst,
   output logic ext_v,
   output logic thr_v,
   output logic rst_v,
   output logic irq_any
);
   always_comb begin
      ext_v   = ext_irq & ext_lvl;
      thr_v   = thr_flag;
      rst_v   = hw_rst;
      irq_any = ext_v | thr_v;
   end
endmodule

// File: rtl/pdwake_fsm.sv
// Run / stopped state; the clock enable is the inverse of the stopped flag.
module pdwake_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic rst_v,
   input  logic irq_any,
   input  logic clr_busy,
   output logic down,
   output logic enter,
   output logic irq_wake,
   output logic clk_en
);
   logic down_q;

   always_comb begin
      enter    = ~down_q & pd_req & ~rst_v & ~clr_busy;
      irq_wake = down_q & irq_any & ~rst_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      down_q <= 1'b0;
      else if (enter)                  down_q <= 1'b1;
      else if (down_q & (rst_v | irq_any)) down_q <= 1'b0;
   end

   assign down   = down_q;
   assign clk_en = ~down_q;
endmodule

// File: rtl/pdwake_clr.sv
// Register / display-memory clear pulse generator.
module pdwake_clr #(
   parameter int CLR_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_v,
   output logic clr,
   output logic pc_zero
);
   localparam int CNT_W = $clog2(CLR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLR_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             pcz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pcz_q <= 1'b0;
      end else begin
         pcz_q <= rst_v;
         if (rst_v)              cnt_q <= CNT_LOAD;
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
   end

   assign clr     = (cnt_q != '0);
   assign pc_zero = pcz_q;
endmodule

// File: rtl/pdwake_stat.sv
// Pending bits, wake-source status and resume flag.
module pdwake_stat
   import pdwake_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            down,
   input  logic            enter,
   input  logic            irq_wake,
   input  logic            ext_v,
   input  logic            thr_v,
   input  logic            rst_v,
   input  logic            rd,
   input  logic [NIRQ-1:0] ack,
   output logic [NIRQ-1:0] pend,
   output logic [1:0]      src,
   output logic            resume
);
   logic [NIRQ-1:0] src_v;
   wake_src_e       src_q;
   logic            res_q;

   assign src_v = {thr_v, ext_v};

   for (genvar i = 0; i < NIRQ; i++) begin : g_pend
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       p_q <= 1'b0;
         else if (rst_v)                   p_q <= 1'b0;
         else if (irq_wake & src_v[i])     p_q <= 1'b1;
         else if (ack[i])                  p_q <= 1'b0;
      end
      assign pend[i] = p_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               src_q <= WK_NONE;
      else if (rst_v & down)    src_q <= WK_RST;
      else if (irq_wake)        src_q <= ext_v ? WK_EXT : WK_THR;
      else if (rd)              src_q <= WK_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          res_q <= 1'b0;
      else if (rst_v)      res_q <= 1'b0;
      else if (irq_wake)   res_q <= 1'b1;
      else if (enter)      res_q <= 1'b0;
   end

   assign src    = src_q;
   assign resume = res_q;
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
   import pdwake_pkg::*;
#(
   parameter int CLR_CYCLES = 2,
   parameter bit REG_WAKE   = 1'b0
) (
   input  logic            clk_aon,
   input  logic            rst_n,
   input  logic            pd_req_i,
   input  logic            ext_irq_i,
   input  logic            ext_lvl_i,
   input  logic            thr_flag_i,
   input  logic            hw_rst_i,
   input  logic            stat_rd_i,
   input  logic [NIRQ-1:0] irq_ack_i,
   output logic            core_clk_en_o,
   output logic [NIRQ-1:0] irq_pend_o,
   output logic [1:0]      wake_src_o,
   output logic            resume_next_o,
   output logic            reg_clr_o,
   output logic            pc_zero_o
);
   if (CLR_CYCLES < 1 || CLR_CYCLES > 255) begin : g_bad_clr
      $error("pdwake_ctrl: CLR_CYCLES must lie in 1..255");
   end

   logic a_ext, a_thr, a_rst, a_any;
   logic ext_v, thr_v, rst_v, irq_any;
   logic down, enter, irq_wake, clr_busy;

   pdwake_arb u_arb (
      .ext_irq (ext_irq_i),
      .ext_lvl (ext_lvl_i),
      .thr_flag(thr_flag_i),
      .hw_rst  (hw_rst_i),
      .ext_v   (a_ext),
      .thr_v   (a_thr),
      .rst_v   (a_rst),
      .irq_any (a_any)
   );

   if (REG_WAKE) begin : g_reg_wake
      logic [3:0] w_q;
      always_ff @(posedge clk_aon or negedge rst_n) begin
         if (!rst_n) w_q <= '0;
         else        w_q <= {a_any, a_rst, a_thr, a_ext};
      end
      assign {irq_any, rst_v, thr_v, ext_v} = w_q;
   end else begin : g_comb_wake
      assign {irq_any, rst_v, thr_v, ext_v} = {a_any, a_rst, a_thr, a_ext};
   end

   pdwake_fsm u_fsm (
      .clk     (clk_aon),
      .rst_n   (rst_n),
      .pd_req  (pd_req_i),
      .rst_v   (rst_v),
      .irq_any (irq_any),
      .clr_busy(clr_busy),
      .down    (down),
      .enter   (enter),
      .irq_wake(irq_wake),
      .clk_en  (core_clk_en_o)
   );

   pdwake_clr #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
      .clk    (clk_aon),
      .rst_n  (rst_n),
      .rst_v  (rst_v),
      .clr    (clr_busy),
      .pc_zero(pc_zero_o)
   );

   assign reg_clr_o = clr_busy;

   pdwake_stat u_stat (
      .clk     (clk_aon),
      .rst_n   (rst_n),
      .down    (down),
      .enter   (enter),
      .irq_wake(irq_wake),
      .ext_v   (ext_v),
      .thr_v   (thr_v),
      .rst_v   (rst_v),
      .rd      (stat_rd_i),
      .ack     (irq_ack_i),
      .pend    (irq_pend_o),
      .src     (wake_src_o),
      .resume  (resume_next_o)
   );
endmodule

// File: rtl/pdwake_ctrl_chk.sv
module pdwake_ctrl_chk #(
   parameter bit REG_WAKE = 1'b0
) (
   input logic       clk_aon,
   input logic       rst_n,
   input logic       pd_req_i,
   input logic       ext_irq_i,
   input logic       ext_lvl_i,
   input logic       thr_flag_i,
   input logic       hw_rst_i,
   input logic       core_clk_en_o,
   input logic [1:0] irq_pend_o,
   input logic [1:0] wake_src_o,
   input logic       reg_clr_o,
   input logic       pc_zero_o
);
   if (!REG_WAKE) begin : g_comb_props
      p_clk_off_r2: assert property (@(posedge clk_aon) disable iff (!rst_n)
         pd_req_i && core_clk_en_o && !hw_rst_i && !reg_clr_o |=> !core_clk_en_o);

      p_edge_ignored_r4: assert property (@(posedge clk_aon) disable iff (!rst_n)
         !core_clk_en_o && !(ext_irq_i && ext_lvl_i) && !thr_flag_i && !hw_rst_i
         |=> !core_clk_en_o);

      p_wake_fast_r3: assert property (@(posedge clk_aon) disable iff (!rst_n)
         !core_clk_en_o && (hw_rst_i || thr_flag_i || (ext_irq_i && ext_lvl_i))
         |=> core_clk_en_o);

      p_rst_prio_r9: assert property (@(posedge clk_aon) disable iff (!rst_n)
         hw_rst_i |=> (irq_pend_o == 2'b00) && reg_clr_o && pc_zero_o);
   end

   p_src_ext_r5: assert property (@(posedge clk_aon) disable iff (!rst_n)
      $rose(irq_pend_o[0]) |-> wake_src_o == 2'd1);

   p_src_thr_r7: assert property (@(posedge clk_aon) disable iff (!rst_n)
      $rose(irq_pend_o[1]) && !$rose(irq_pend_o[0]) |-> wake_src_o == 2'd2);

   p_clr_running_r8: assert property (@(posedge clk_aon) disable iff (!rst_n)
      reg_clr_o |-> core_clk_en_o);
endmodule

bind pdwake_ctrl pdwake_ctrl_chk #(.REG_WAKE(REG_WAKE)) u_chk (
   .clk_aon      (clk_aon),
   .rst_n        (rst_n),
   .pd_req_i     (pd_req_i),
   .ext_irq_i    (ext_irq_i),
   .ext_lvl_i    (ext_lvl_i),
   .thr_flag_i   (thr_flag_i),
   .hw_rst_i     (hw_rst_i),
   .core_clk_en_o(core_clk_en_o),
   .irq_pend_o   (irq_pend_o),
   .wake_src_o   (wake_src_o),
   .reg_clr_o    (reg_clr_o),
   .pc_zero_o    (pc_zero_o)
);

// File: tb/pdwake_ctrl_bench.sv
module pdwake_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd = 0, ext = 0, lvl = 0, thr = 0, hrst = 0, rd = 0;
   logic [1:0] ack = 2'b00;
   logic       en, res, clr, pcz;
   logic [1:0] pend, src;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic       en;
      logic [1:0] pend;
      logic [1:0] src;
      logic       clr;
      logic       pc;
      logic       res;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   pdwake_ctrl u_pdwake_ctrl (
      .clk_aon      (clk),
      .rst_n        (rst_n),
      .pd_req_i     (pd),
      .ext_irq_i    (ext),
      .ext_lvl_i    (lvl),
      .thr_flag_i   (thr),
      .hw_rst_i     (hrst),
      .stat_rd_i    (rd),
      .irq_ack_i    (ack),
      .core_clk_en_o(en),
      .irq_pend_o   (pend),
      .wake_src_o   (src),
      .resume_next_o(res),
      .reg_clr_o    (clr),
      .pc_zero_o    (pcz)
   );

   task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Driver: applies inputs at the falling edge and queues the outputs
   // expected after the next rising edge.
   task automatic step(input logic i_pd, i_ext, i_lvl, i_thr, i_rst, i_rd,
                       input logic [1:0] i_ack,
                       input logic e_en, input logic [1:0] e_pend, e_src,
                       input logic e_clr, e_pc, e_res, input string tag);
      exp_t e;
      @(negedge clk);
      pd = i_pd; ext = i_ext; lvl = i_lvl; thr = i_thr; hrst = i_rst; rd = i_rd; ack = i_ack;
      e.en = e_en; e.pend = e_pend; e.src = e_src; e.clr = e_clr; e.pc = e_pc; e.res = e_res; e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: pops one expectation per rising edge and compares.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "clk_en", {1'b0, en}, {1'b0, e.en});
            chk(e.tag, "pend", pend, e.pend);
            chk(e.tag, "src", src, e.src);
            chk(e.tag, "clr", {1'b0, clr}, {1'b0, e.clr});
            chk(e.tag, "pc_zero", {1'b0, pcz}, {1'b0, e.pc});
            chk(e.tag, "resume", {1'b0, res}, {1'b0, e.res});
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #5;
      chk("R1", "clk_en in reset", {1'b0, en}, 2'd1);
      chk("R1", "pend in reset", pend, 2'd0);
      chk("R1", "src in reset", src, 2'd0);
      @(negedge clk);
      rst_n = 1'b1;
      //    pd ext lvl thr rst rd ack    en pend  src  clr pc res
      step(0, 0, 0, 0, 0, 0, 2'b00,  1, 2'b00, 2'd0, 0, 0, 0, "R1 idle");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd0, 0, 0, 0, "R2 enter");
      step(0, 1, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd0, 0, 0, 0, "R4 edge cfg");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd0, 0, 0, 0, "R2 stays off");
      step(0, 1, 1, 0, 0, 0, 2'b00,  1, 2'b01, 2'd1, 0, 0, 1, "R3 R5 ext wake");
      step(0, 0, 0, 0, 0, 0, 2'b01,  1, 2'b00, 2'd1, 0, 0, 1, "R5 ack");
      step(0, 0, 0, 0, 0, 1, 2'b00,  1, 2'b00, 2'd0, 0, 0, 1, "R10 read");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd0, 0, 0, 0, "R6 entry clears");
      step(0, 0, 0, 1, 0, 0, 2'b00,  1, 2'b10, 2'd2, 0, 0, 1, "R7 thr wake");
      step(0, 0, 0, 0, 0, 0, 2'b10,  1, 2'b00, 2'd2, 0, 0, 1, "R7 ack");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd2, 0, 0, 0, "R2 enter again");
      step(0, 1, 1, 0, 1, 0, 2'b00,  1, 2'b00, 2'd3, 1, 1, 0, "R9 R8 reset wins");
      step(1, 0, 0, 0, 0, 0, 2'b00,  1, 2'b00, 2'd3, 1, 0, 0, "R8 pd during clear");
      step(0, 0, 0, 0, 0, 0, 2'b00,  1, 2'b00, 2'd3, 0, 0, 0, "R8 clear ends");
      step(1, 0, 0, 0, 0, 1, 2'b00,  0, 2'b00, 2'd0, 0, 0, 0, "R10 read on entry");
      step(0, 1, 1, 0, 0, 1, 2'b00,  1, 2'b01, 2'd1, 0, 0, 1, "R10 wake beats read");
      step(0, 0, 0, 0, 0, 0, 2'b01,  1, 2'b00, 2'd1, 0, 0, 1, "R5 ack2");
      step(1, 1, 1, 0, 0, 0, 2'b00,  0, 2'b00, 2'd1, 0, 0, 0, "R11 irq while running");
      step(0, 1, 1, 0, 0, 0, 2'b00,  1, 2'b01, 2'd1, 0, 0, 1, "R3 wake held line");
      step(0, 1, 1, 0, 0, 0, 2'b01,  1, 2'b00, 2'd1, 0, 0, 1, "R11 no re-pend");
      step(1, 0, 0, 0, 1, 0, 2'b00,  1, 2'b00, 2'd1, 1, 1, 0, "R8 R10 reset running");
      step(0, 0, 0, 0, 0, 0, 2'b00,  1, 2'b00, 2'd1, 1, 0, 0, "R8 clear cycle 2");
      step(0, 0, 0, 0, 0, 0, 2'b00,  1, 2'b00, 2'd1, 0, 0, 0, "R8 clear done");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd1, 0, 0, 0, "R2 enter 3");
      step(0, 1, 1, 1, 0, 0, 2'b00,  1, 2'b11, 2'd1, 0, 0, 1, "R12 both wake");
      step(0, 0, 0, 0, 0, 0, 2'b11,  1, 2'b00, 2'd1, 0, 0, 1, "R5 ack both");
      step(1, 0, 0, 0, 0, 0, 2'b00,  0, 2'b00, 2'd1, 0, 0, 0, "R6 entry 4");
      step(0, 1, 0, 1, 0, 0, 2'b00,  1, 2'b10, 2'd2, 0, 0, 1, "R4 R7 edge ext plus thr");
      step(0, 0, 0, 0, 0, 0, 2'b00,  1, 2'b10, 2'd2, 0, 0, 1, "R5 pend holds");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule